// File: doc/BRIEF.md
# Disk Controller Command and Status Port

This block is the controller-side register face of a disk controller that serves several drives. Software loads a target disk address one byte at a time: a sector byte, then the upper and lower bytes of a combined head/cylinder word. A pointer walks through the three slots in turn and wraps. A command byte carries a 6-bit function field and an optional update of the controller interrupt arm. An 8-bit status byte reports the error flags, idle and busy, and a summary exception bit.

When the controller is idle and the selected drive is not busy, a valid function is accepted. The block then marks itself busy, clears old errors and sends a one-clock start pulse with the function code to a transfer engine. That engine later reports completion on a done strobe with an error flag byte. While a transfer runs, drive-level interrupt requests are held back in a save register. They are released together when the transfer completes. A function with the reset bit set returns the whole controller to its power-on state and pulses a reset toward the drives.

Top module: `dsk_ctl_port`

## Requirements
- R1: After rst_n low, and one clock after a command whose bit 3 is set, status reads 0x0A (idle and busy both set). In the same state sector, head/cylinder, selected unit, controller arm, controller interrupt and all drive interrupt bits are 0. A command with bit 3 set also gives a one-clock drv_reset pulse.
- R2: Byte address writes fill three slots in a repeating order. Slot 0 is sector, slot 1 is head_cyl[15:8] and slot 2 is head_cyl[7:0]; after slot 2 the pointer wraps to slot 0.
- R3: A halfword address write applies addr_data[15:8] to the current slot and then addr_data[7:0] to the slot after it. Every command write, whatever its value, returns the slot pointer to 0 and drops any address write in the same cycle.
- R4: Status bit positions are: 7 write protect, 6 address compare fail, 5 defective track, 4 cylinder overflow, 3 busy, 2 exception, 1 idle, 0 transfer error. Bit 2 reads 1 exactly when any of bits 7..4 is 1.
- R5: cmd_data[5:0] is the function field. When cmd_data[7] is 1 the controller arm takes the value of cmd_data[6]. An accepted function gives start high for exactly one clock, with start_cmd equal to the field.
- R6: A command is dropped (no start, no status change) when its field is 0x00 or 0x12, when idle is 0, or when unit_busy[cur_unit] is 1.
- R7: Acceptance sets status to 0x08 (busy only). Drive interrupts pending at that moment, and any drive requests arriving during the transfer, are held and drv_irq reads 0 until completion.
- R8: done_valid is taken only while busy is 1. It sets idle, ORs in done_flags masked with 0xF1, clears busy and releases the held drive interrupts. It raises ctl_irq if armed, and pulses chan_stop for one clock when the masked flags are nonzero.
- R9: sel_wr loads cur_unit from sel_unit only while idle is 1.
- R10: Each drv_req bit sets its drv_irq bit while no transfer runs, and the matching drv_ack bit clears it. ctl_ack clears ctl_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_wr | input | 1 | Address write strobe |
| addr_half | input | 1 | Address write carries two bytes |
| addr_data | input | 16 | Address write data (byte in [7:0]) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Arm control [7:6], function field [5:0] |
| sel_wr | input | 1 | Drive select strobe |
| sel_unit | input | UNIT_W | Drive number to select |
| unit_busy | input | NUM_DRIVES | Per-drive busy indication |
| done_valid | input | 1 | Transfer completion strobe |
| done_flags | input | 8 | Completion error flags, status layout |
| drv_req | input | NUM_DRIVES | Drive interrupt request pulses |
| drv_ack | input | NUM_DRIVES | Drive interrupt clear pulses |
| ctl_ack | input | 1 | Controller interrupt clear |
| status | output | 8 | Status byte |
| sector | output | 8 | Loaded sector |
| head_cyl | output | 16 | Loaded head/cylinder word |
| cur_unit | output | UNIT_W | Selected drive |
| start | output | 1 | One-clock start toward the transfer engine |
| start_cmd | output | 6 | Function field of the accepted command |
| chan_stop | output | 1 | One-clock stop after an error completion |
| drv_reset | output | 1 | One-clock reset toward the drives |
| ctl_irq | output | 1 | Controller interrupt request |
| drv_irq | output | NUM_DRIVES | Drive interrupt requests |

## Verification
The bench builds the block with NUM_DRIVES = 4. At that size it can pair each of the four units with all sixteen unit-busy masks. It also runs every one of the 64 function fields through acceptance and every one of the 256 completion flag bytes through the status byte and the exception bit. A mixed stream of byte, halfword and command writes is checked slot by slot against an arithmetic model of the rolling pointer.

// File: rtl/dcp_pkg.sv
// Shared constants and types for the disk controller command/status port.
// Assumes an 8-bit status byte with the fixed bit layout given below.
package dcp_pkg;
    localparam int BYTE_W   = 8;
    localparam int FIELD_W  = 6;
    localparam int HCYL_W   = 2 * BYTE_W;
    localparam int SLOT_CNT = 3;
    localparam int SLOT_W   = $clog2(SLOT_CNT + 1);

    localparam int ST_WP  = 7;
    localparam int ST_ACF = 6;
    localparam int ST_DEF = 5;
    localparam int ST_CYO = 4;
    localparam int ST_BSY = 3;
    localparam int ST_EXC = 2;
    localparam int ST_IDL = 1;
    localparam int ST_DTE = 0;

    localparam logic [BYTE_W-1:0]  ERR_MASK  = 8'hF1;
    localparam logic [BYTE_W-1:0]  ST_RESET  = 8'h0A;
    localparam logic [BYTE_W-1:0]  ST_ACTIVE = 8'h08;
    localparam logic [FIELD_W-1:0] FN_NOP    = 6'h00;
    localparam logic [FIELD_W-1:0] FN_SKIP   = 6'h12;
    localparam int                 FN_RST_BIT = 3;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BYTE_W-1:0] sec;
        logic [HCYL_W-1:0] hcyl;
    } addr_state_t;
endpackage

// File: rtl/dcp_addr_load.sv
// Rolling three-slot address loader: sector, head/cyl high, head/cyl low.
// Assumes a halfword write is one byte to the current slot, then one to the next.
module dcp_addr_load
    import dcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              slot_clr,
    input  logic              wr_en,
    input  logic              wr_half,
    input  logic [HCYL_W-1:0] wr_data,
    output logic [BYTE_W-1:0] sector,
    output logic [HCYL_W-1:0] head_cyl
);
    addr_state_t cur_q, cur_d;

    // Place one byte into the slot named by the pointer and advance it.
    function automatic addr_state_t put_byte(input addr_state_t s, input logic [BYTE_W-1:0] b);
        addr_state_t r;
        r = s;
        case (s.slot)
            SLOT_W'(0): begin r.sec = b;                      r.slot = SLOT_W'(1); end
            SLOT_W'(1): begin r.hcyl[HCYL_W-1:BYTE_W] = b;    r.slot = SLOT_W'(2); end
            default:    begin r.hcyl[BYTE_W-1:0] = b;         r.slot = SLOT_W'(0); end
        endcase
        return r;
    endfunction

    // Next address state: reset, pointer clear, or one/two byte loads.
    always_comb begin
        cur_d = cur_q;
        if (soft_rst) begin
            cur_d = '0;
        end else if (slot_clr) begin
            cur_d.slot = '0;
        end else if (wr_en) begin
            if (wr_half)
                cur_d = put_byte(put_byte(cur_q, wr_data[HCYL_W-1:BYTE_W]), wr_data[BYTE_W-1:0]);
            else
                cur_d = put_byte(cur_q, wr_data[BYTE_W-1:0]);
        end
    end

    // Address state register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign sector   = cur_q.sec;
    assign head_cyl = cur_q.hcyl;
endmodule

// File: rtl/dcp_stat_core.sv
// Status register, command acceptance, completion handling and unit select.
// Assumes done is meaningful only while busy; start is a registered pulse.
module dcp_stat_core
    import dcp_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int UNIT_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_wr,
    input  logic [FIELD_W-1:0]    cmd_field,
    input  logic                  sel_wr,
    input  logic [UNIT_W-1:0]     sel_unit,
    input  logic [NUM_DRIVES-1:0] unit_busy,
    input  logic                  done_valid,
    input  logic [BYTE_W-1:0]     done_flags,
    output logic [BYTE_W-1:0]     stat_q,
    output logic                  soft_rst,
    output logic                  xfer_begin,
    output logic                  xfer_end,
    output logic                  xfer_hold,
    output logic [UNIT_W-1:0]     cur_unit,
    output logic                  start,
    output logic [FIELD_W-1:0]    start_cmd,
    output logic                  chan_stop,
    output logic                  drv_reset
);
    logic [BYTE_W-1:0] stat_d;
    logic [BYTE_W-1:0] err_in;
    logic              is_idle;
    logic              is_busy;
    logic              fn_valid;

    assign is_idle  = stat_q[ST_IDL];
    assign is_busy  = stat_q[ST_BSY];
    assign err_in   = done_flags & ERR_MASK;
    assign fn_valid = (cmd_field != FN_NOP) && (cmd_field != FN_SKIP);

    // Classify this cycle's command and completion events.
    always_comb begin
        soft_rst   = cmd_wr && cmd_field[FN_RST_BIT];
        xfer_begin = cmd_wr && !cmd_field[FN_RST_BIT] && fn_valid
                     && is_idle && !unit_busy[cur_unit];
        xfer_end   = done_valid && is_busy && !soft_rst && !xfer_begin;
        xfer_hold  = is_busy && !is_idle;
    end

    // Next status byte from reset, acceptance or completion.
    always_comb begin
        stat_d = stat_q;
        if (soft_rst)
            stat_d = ST_RESET;
        else if (xfer_begin)
            stat_d = ST_ACTIVE;
        else if (xfer_end) begin
            stat_d = stat_q | err_in;
            stat_d[ST_IDL] = 1'b1;
            stat_d[ST_BSY] = 1'b0;
        end
    end

    // Status register; hardware reset leaves idle and busy set.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= ST_RESET;
        else        stat_q <= stat_d;
    end

    // Selected drive number, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)   cur_unit <= '0;
        else if (sel_wr && is_idle) cur_unit <= sel_unit;
    end

    // One-clock pulses toward the transfer engine, channel and drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start     <= 1'b0;
            start_cmd <= '0;
            chan_stop <= 1'b0;
            drv_reset <= 1'b0;
        end else begin
            start     <= xfer_begin;
            chan_stop <= xfer_end && (err_in != '0);
            drv_reset <= soft_rst;
            if (xfer_begin) start_cmd <= cmd_field;
        end
    end
endmodule

// File: rtl/dcp_irq_hold.sv
// Controller arm/interrupt and per-drive interrupt pending/save logic.
// Assumes begin, end and hold come from the status core as mutually consistent.
module dcp_irq_hold #(
    parameter int NUM_DRIVES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  arm_wr,
    input  logic                  arm_val,
    input  logic                  xfer_begin,
    input  logic                  xfer_end,
    input  logic                  xfer_hold,
    input  logic                  ctl_ack,
    input  logic [NUM_DRIVES-1:0] drv_req,
    input  logic [NUM_DRIVES-1:0] drv_ack,
    output logic                  ctl_irq,
    output logic [NUM_DRIVES-1:0] drv_irq
);
    logic armed_q;

    // Controller interrupt arm, updated by command writes.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) armed_q <= 1'b0;
        else if (arm_wr)        armed_q <= arm_val;
    end

    // Controller interrupt: raised at an armed completion, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)      ctl_irq <= 1'b0;
        else if (xfer_end && armed_q) ctl_irq <= 1'b1;
        else if (ctl_ack)             ctl_irq <= 1'b0;
    end

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        logic pend_q;
        logic save_q;

        // Per-drive pending and saved request bits.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                pend_q <= 1'b0;
                save_q <= 1'b0;
            end else if (xfer_begin) begin
                save_q <= pend_q | drv_req[d];
                pend_q <= 1'b0;
            end else if (xfer_end) begin
                pend_q <= pend_q | save_q | drv_req[d];
                save_q <= 1'b0;
            end else if (xfer_hold) begin
                save_q <= save_q | drv_req[d];
            end else begin
                pend_q <= (pend_q & ~drv_ack[d]) | drv_req[d];
            end
        end

        assign drv_irq[d] = pend_q;
    end
endmodule

// File: rtl/dsk_ctl_port.sv
// Top of the controller command/status port: joins the address loader,
// the status core and the interrupt holder. Assumes NUM_DRIVES is a power of two.
module dsk_ctl_port
    import dcp_pkg::*;
#(
    parameter  int NUM_DRIVES = 4,
    localparam int UNIT_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  addr_wr,
    input  logic                  addr_half,
    input  logic [15:0]           addr_data,
    input  logic                  cmd_wr,
    input  logic [7:0]            cmd_data,
    input  logic                  sel_wr,
    input  logic [UNIT_W-1:0]     sel_unit,
    input  logic [NUM_DRIVES-1:0] unit_busy,
    input  logic                  done_valid,
    input  logic [7:0]            done_flags,
    input  logic [NUM_DRIVES-1:0] drv_req,
    input  logic [NUM_DRIVES-1:0] drv_ack,
    input  logic                  ctl_ack,
    output logic [7:0]            status,
    output logic [7:0]            sector,
    output logic [15:0]           head_cyl,
    output logic [UNIT_W-1:0]     cur_unit,
    output logic                  start,
    output logic [5:0]            start_cmd,
    output logic                  chan_stop,
    output logic                  drv_reset,
    output logic                  ctl_irq,
    output logic [NUM_DRIVES-1:0] drv_irq
);
    logic [BYTE_W-1:0] stat_q;
    logic              soft_rst;
    logic              xfer_begin;
    logic              xfer_end;
    logic              xfer_hold;

    dcp_addr_load u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .slot_clr (cmd_wr),
        .wr_en    (addr_wr),
        .wr_half  (addr_half),
        .wr_data  (addr_data),
        .sector   (sector),
        .head_cyl (head_cyl)
    );

    dcp_stat_core #(.NUM_DRIVES(NUM_DRIVES), .UNIT_W(UNIT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_field  (cmd_data[FIELD_W-1:0]),
        .sel_wr     (sel_wr),
        .sel_unit   (sel_unit),
        .unit_busy  (unit_busy),
        .done_valid (done_valid),
        .done_flags (done_flags),
        .stat_q     (stat_q),
        .soft_rst   (soft_rst),
        .xfer_begin (xfer_begin),
        .xfer_end   (xfer_end),
        .xfer_hold  (xfer_hold),
        .cur_unit   (cur_unit),
        .start      (start),
        .start_cmd  (start_cmd),
        .chan_stop  (chan_stop),
        .drv_reset  (drv_reset)
    );

    dcp_irq_hold #(.NUM_DRIVES(NUM_DRIVES)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .arm_wr     (cmd_wr && cmd_data[7]),
        .arm_val    (cmd_data[6]),
        .xfer_begin (xfer_begin),
        .xfer_end   (xfer_end),
        .xfer_hold  (xfer_hold),
        .ctl_ack    (ctl_ack),
        .drv_req    (drv_req),
        .drv_ack    (drv_ack),
        .ctl_irq    (ctl_irq),
        .drv_irq    (drv_irq)
    );

    // Status byte with the exception summary folded into its bit.
    always_comb begin
        status         = stat_q;
        status[ST_EXC] = (stat_q[ST_WP:ST_CYO] != '0);
    end
endmodule

// File: rtl/dcp_chk.sv
// Assertion checker for the command/status port, bound to the top module.
// Assumes only top-level ports; no internal state is observed.
module dcp_chk #(
    parameter int NUM_DRIVES = 4,
    parameter int UNIT_W     = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_wr,
    input logic                  cmd_rst,
    input logic                  done_valid,
    input logic                  done_wp,
    input logic [7:0]            status,
    input logic                  start,
    input logic [UNIT_W-1:0]     cur_unit,
    input logic                  drv_reset,
    input logic                  ctl_irq,
    input logic [NUM_DRIVES-1:0] drv_irq
);
    AST_START_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R5

    AST_ACCEPT_BUSY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> status == 8'h08); // R7

    AST_DRV_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !status[1]) |-> drv_irq == '0); // R7

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && status[3] && !status[1] && !cmd_wr) |=> (status[1] && !status[3])); // R8

    AST_SOFT_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_rst) |=> (status == 8'h0A && !ctl_irq && drv_irq == '0 && drv_reset)); // R1

    AST_NOT_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_rst && !status[1]) |=> !start); // R6

    AST_EXC_AFTER_WP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_wp && status[3] && !status[1] && !cmd_wr) |=> (status[7] && status[2])); // R4

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[1] && !(cmd_wr && cmd_rst)) |=> $stable(cur_unit)); // R9
endmodule

bind dsk_ctl_port dcp_chk #(.NUM_DRIVES(NUM_DRIVES), .UNIT_W(UNIT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_rst    (cmd_data[3]),
    .done_valid (done_valid),
    .done_wp    (done_flags[7]),
    .status     (status),
    .start      (start),
    .cur_unit   (cur_unit),
    .drv_reset  (drv_reset),
    .ctl_irq    (ctl_irq),
    .drv_irq    (drv_irq)
);

// File: tb/sim_dsk_ctl_port.sv
// Self-checking bench: sweeps function fields, completion flags, unit/busy
// combinations and address write streams against arithmetic expectations.
module sim_dsk_ctl_port;
    localparam int ND = 4;
    localparam int UW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          addr_wr, addr_half;
    logic [15:0]   addr_data;
    logic          cmd_wr;
    logic [7:0]    cmd_data;
    logic          sel_wr;
    logic [UW-1:0] sel_unit;
    logic [ND-1:0] unit_busy;
    logic          done_valid;
    logic [7:0]    done_flags;
    logic [ND-1:0] drv_req, drv_ack;
    logic          ctl_ack;
    logic [7:0]    status, sector;
    logic [15:0]   head_cyl;
    logic [UW-1:0] cur_unit;
    logic          start, chan_stop, drv_reset, ctl_irq;
    logic [5:0]    start_cmd;
    logic [ND-1:0] drv_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Address model
    int       m_slot;
    bit [7:0] m_sec;
    bit [15:0] m_hc;

    always #10 clk = ~clk;

    dsk_ctl_port #(.NUM_DRIVES(ND)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_half(addr_half),
        .addr_data(addr_data), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .sel_wr(sel_wr), .sel_unit(sel_unit), .unit_busy(unit_busy),
        .done_valid(done_valid), .done_flags(done_flags), .drv_req(drv_req),
        .drv_ack(drv_ack), .ctl_ack(ctl_ack), .status(status), .sector(sector),
        .head_cyl(head_cyl), .cur_unit(cur_unit), .start(start),
        .start_cmd(start_cmd), .chan_stop(chan_stop), .drv_reset(drv_reset),
        .ctl_irq(ctl_irq), .drv_irq(drv_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic do_cmd(input logic [7:0] b);
        cmd_wr = 1'b1; cmd_data = b;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_data = 8'h00;
    endtask

    task automatic do_done(input logic [7:0] f);
        done_valid = 1'b1; done_flags = f;
        @(negedge clk);
        done_valid = 1'b0; done_flags = 8'h00;
    endtask

    task automatic do_sel(input logic [UW-1:0] u);
        sel_wr = 1'b1; sel_unit = u;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic do_addr(input bit half, input logic [15:0] d);
        addr_wr = 1'b1; addr_half = half; addr_data = d;
        @(negedge clk);
        addr_wr = 1'b0; addr_half = 1'b0;
    endtask

    function automatic void model_byte(input bit [7:0] b);
        case (m_slot)
            0: begin m_sec = b; m_slot = 1; end
            1: begin m_hc[15:8] = b; m_slot = 2; end
            default: begin m_hc[7:0] = b; m_slot = 0; end
        endcase
    endfunction

    function automatic logic [7:0] exp_status_after_done(input logic [7:0] f);
        logic [7:0] s;
        s = 8'h02 | (f & 8'hF1);
        if ((f & 8'hF0) != 0) s = s | 8'h04;
        return s;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=0 exp=1");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr_wr = 0; addr_half = 0; addr_data = 0;
        cmd_wr = 0; cmd_data = 0; sel_wr = 0; sel_unit = 0; unit_busy = 0;
        done_valid = 0; done_flags = 0; drv_req = 0; drv_ack = 0; ctl_ack = 0;
        m_slot = 0; m_sec = 0; m_hc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: hardware reset state
        chk("R1 status", status, 8'h0A);
        chk("R1 sector", sector, 0);
        chk("R1 head_cyl", head_cyl, 0);
        chk("R1 cur_unit", cur_unit, 0);
        chk("R1 ctl_irq", ctl_irq, 0);
        chk("R1 drv_irq", drv_irq, 0);

        // R5 R6 R7 R8 R1: every function field
        for (int f = 0; f < 64; f++) begin
            bit acc;
            acc = (f != 0) && (f != 'h12) && ((f & 8) == 0);
            do_cmd(8'(f));
            chk("R5/R6 start", start, acc);
            if (acc) begin
                chk("R5 start_cmd", start_cmd, f);
                chk("R7 status", status, 8'h08);
                do_done(8'h00);
                chk("R8 status", status, 8'h02);
            end else if ((f & 8) != 0) begin
                chk("R1 soft status", status, 8'h0A);
                chk("R1 drv_reset", drv_reset, 1);
            end
            @(negedge clk);
        end

        // R8 R4 R5 R10: every completion flag byte, arm toggled by parity
        for (int fl = 0; fl < 256; fl++) begin
            bit armed;
            armed = (fl % 2) == 0;
            do_cmd(armed ? 8'hC1 : 8'h81);
            chk("R7 accept status", status, 8'h08);
            do_done(8'(fl));
            chk("R4/R8 status", status, exp_status_after_done(8'(fl)));
            chk("R8 chan_stop", chan_stop, ((fl & 'hF1) != 0));
            chk("R8 ctl_irq", ctl_irq, armed);
            ctl_ack = 1'b1;
            @(negedge clk);
            ctl_ack = 1'b0;
            chk("R10 ctl_ack", ctl_irq, 0);
            // R8: done with busy clear is ignored
            do_done(8'hFF);
            chk("R8 done ignored", status, exp_status_after_done(8'(fl)));
        end

        // R6 R9: every unit against every busy mask
        for (int u = 0; u < ND; u++) begin
            for (int m = 0; m < 16; m++) begin
                bit acc;
                do_sel(UW'(u));
                chk("R9 select", cur_unit, u);
                unit_busy = 4'(m);
                acc = ((m >> u) & 1) == 0;
                do_cmd(8'h02);
                chk("R6 unit busy", start, acc);
                unit_busy = '0;
                if (acc) begin
                    do_sel(UW'(u + 1));
                    chk("R9 select frozen", cur_unit, u);
                    do_cmd(8'h01);
                    chk("R6 not idle start", start, 0);
                    chk("R6 not idle status", status, 8'h08);
                    do_done(8'h00);
                end
            end
        end

        // R2 R3: mixed address stream
        do_cmd(8'h00);
        m_slot = 0;
        for (int i = 0; i < 60; i++) begin
            if (i % 5 == 4) begin
                do_cmd(8'h00);
                m_slot = 0;
                chk("R3 nop no start", start, 0);
            end else if (i % 3 == 1) begin
                logic [15:0] hw;
                hw = 16'(i * 16'h1357 + 5);
                do_addr(1'b1, hw);
                model_byte(hw[15:8]);
                model_byte(hw[7:0]);
                chk("R3 half sector", sector, m_sec);
                chk("R3 half head_cyl", head_cyl, m_hc);
            end else begin
                logic [7:0] b;
                b = 8'(i * 37 + 11);
                do_addr(1'b0, {8'hA5, b});
                model_byte(b);
                chk("R2 byte sector", sector, m_sec);
                chk("R2 byte head_cyl", head_cyl, m_hc);
            end
        end

        // R10 R7 R8: drive interrupt hold and release
        drv_req = 4'b0101;
        @(negedge clk);
        drv_req = '0;
        chk("R10 drv_req", drv_irq, 4'b0101);
        do_cmd(8'hC1);
        chk("R7 drv held", drv_irq, 4'b0000);
        drv_req = 4'b1000;
        @(negedge clk);
        drv_req = '0;
        chk("R7 drv deferred", drv_irq, 4'b0000);
        do_done(8'h00);
        chk("R8 drv restored", drv_irq, 4'b1101);
        chk("R8 ctl_irq armed", ctl_irq, 1);
        drv_ack = 4'b0001;
        @(negedge clk);
        drv_ack = '0;
        chk("R10 drv_ack", drv_irq, 4'b1100);

        // R1: soft reset clears everything, including the arm
        do_sel(2'd3);
        do_addr(1'b0, 16'h0077);
        do_cmd(8'h08);
        chk("R1 soft status", status, 8'h0A);
        chk("R1 soft ctl_irq", ctl_irq, 0);
        chk("R1 soft drv_irq", drv_irq, 0);
        chk("R1 soft cur_unit", cur_unit, 0);
        chk("R1 soft sector", sector, 0);
        do_cmd(8'h01);
        do_done(8'h00);
        chk("R1 arm cleared", ctl_irq, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule